// File: doc/BRIEF.md
# Reset Timeout Extender with Fuse-Selected Count Profiles

This block keeps the internal processor reset asserted for as long as any reset request is active, then holds it for a further timeout before releasing it. Three requests feed it: power-on, the external reset pin and the watchdog. Three static configuration bits also feed it: a clock-select bit, a pin-reset-keep bit and a debug-off bit. Together, the highest-priority request cause and these bits pick a count profile. A profile is either a single phase, or a system-clock phase followed by a tail phase.

All inputs share one clock, `clk`. Three single-cycle strobes (`sys_tick`, `rc_tick`, `ext_tick`) mark the edges of the system clock, the fast RC clock and the external clock. Only the strobe that belongs to the active phase advances the count. The block also keeps a registered code for the last reset cause. It pulses a flag when a pin request arrives while the configuration bits disable the pin.

Top module: `rst_stretch`

## Requirements
- R1: While any accepted request is active, `core_rst` is 1 from the clock edge after the request is sampled. Counting starts only at the first edge where all requests are inactive, and it counts from zero.
- R2: For a power-on cause with `cfg_xclk_off`=1, `cfg_pin_keep`=1 and `cfg_dbg_off`=1, the release occurs on the edge that samples the 142nd `rc_tick`.
- R3: For a power-on cause with `cfg_xclk_off`=1 and either `cfg_pin_keep`=0 or `cfg_dbg_off`=0, the block first counts 512 `sys_tick` and then 140 `rc_tick`.
- R4: For a power-on cause with `cfg_xclk_off`=0, the block counts 141 `ext_tick`, whatever the other two bits are.
- R5: `pin_req` is accepted only when `cfg_pin_keep`=1 and `cfg_dbg_off`=1. An accepted pin cause counts 140 `rc_tick` when `cfg_xclk_off`=1 and 141 `ext_tick` when `cfg_xclk_off`=0.
- R6: A watchdog cause counts 512 `sys_tick`, then 140 ticks. The second phase uses `rc_tick` when `cfg_xclk_off`=1 and `ext_tick` when `cfg_xclk_off`=0.
- R7: Strobes that do not belong to the active phase have no effect on the count.
- R8: A request that arrives during the timeout sets `core_rst` to 1 at the next edge. Once all requests are inactive again, counting restarts from the first phase of the new cause's profile.
- R9: `cause` is a registered code: 2'b01 for power-on, 2'b10 for pin and 2'b11 for watchdog. While requests are active it follows the highest active one, with power-on above watchdog and watchdog above pin. After release it holds its value until the next accepted request.
- R10: When `pin_req` rises while the pin is disabled, `pin_ignored` is 1 for exactly the one cycle after that edge. Such a request leaves `core_rst` and `cause` unchanged.
- R11: While `rst_n` is 0, `core_rst`=1, `cause`=2'b01 and `pin_ignored`=0. After `rst_n` rises with no request active, a power-on timeout runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous flop reset, active low |
| por_req | input | 1 | Power-on reset request |
| pin_req | input | 1 | External pin reset request |
| wdt_req | input | 1 | Watchdog reset request |
| cfg_xclk_off | input | 1 | 1: internal RC clock, 0: external clock |
| cfg_pin_keep | input | 1 | 1: reset pin kept as a reset input |
| cfg_dbg_off | input | 1 | 1: debug link off |
| sys_tick | input | 1 | System clock strobe |
| rc_tick | input | 1 | Fast RC clock strobe |
| ext_tick | input | 1 | External clock strobe |
| core_rst | output | 1 | Stretched internal reset, active high |
| cause | output | 2 | Last reset cause code |
| pin_ignored | output | 1 | One-cycle pulse for a disabled pin request |

## Verification
Two situations are the hardest to reach from the ports. The first is a request landing in the middle of a running timeout, which must throw away a partly counted profile. The bench starts a watchdog timeout, lets some system ticks pass, then raises the pin request and checks the restart and the new profile. The second is the handover from the system-clock phase to the tail phase. Random strobes of all three kinds run in every cycle, so foreign strobes fall on the handover edge and on the final edge, and the bench's own phase model predicts the exact release edge.

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int SYS_LEN   = 512,
  parameter int RC_SOLO   = 142,
  parameter int TAIL_LEN  = 140,
  parameter int EXT_SOLO  = 141
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_req,
  input  logic       pin_req,
  input  logic       wdt_req,
  input  logic       cfg_xclk_off,
  input  logic       cfg_pin_keep,
  input  logic       cfg_dbg_off,
  input  logic       sys_tick,
  input  logic       rc_tick,
  input  logic       ext_tick,
  output logic       core_rst,
  output logic [1:0] cause,
  output logic       pin_ignored
);
  localparam int M1   = (SYS_LEN > RC_SOLO) ? SYS_LEN : RC_SOLO;
  localparam int M2   = (TAIL_LEN > EXT_SOLO) ? TAIL_LEN : EXT_SOLO;
  localparam int MAXN = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXN + 1);
  localparam logic [1:0] C_POR = 2'b01, C_PIN = 2'b10, C_WDT = 2'b11;

  typedef enum logic [1:0] {ST_HOLD, ST_SYS, ST_TAIL, ST_RUN} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic          pin_d;

  wire pin_ok  = cfg_pin_keep & cfg_dbg_off;
  wire any_req = por_req | wdt_req | (pin_req & pin_ok);
  wire [1:0] prio = por_req ? C_POR : (wdt_req ? C_WDT : C_PIN);

  logic          need_sys;
  logic          tail_ext;
  logic [CW-1:0] tail_len;

  always_comb begin
    need_sys = 1'b0;
    tail_ext = ~cfg_xclk_off;
    tail_len = CW'(TAIL_LEN);
    case (cause)
      C_POR: begin
        if (!cfg_xclk_off)     tail_len = CW'(EXT_SOLO);
        else if (pin_ok)       tail_len = CW'(RC_SOLO);
        else                   need_sys = 1'b1;
      end
      C_PIN: tail_len = cfg_xclk_off ? CW'(TAIL_LEN) : CW'(EXT_SOLO);
      default: need_sys = 1'b1;
    endcase
  end

  wire tail_tick = tail_ext ? ext_tick : rc_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_HOLD;
      cnt         <= '0;
      cause       <= C_POR;
      pin_d       <= 1'b0;
      pin_ignored <= 1'b0;
    end else begin
      pin_d       <= pin_req;
      pin_ignored <= pin_req & ~pin_d & ~pin_ok;
      if (any_req) begin
        st    <= ST_HOLD;
        cnt   <= '0;
        cause <= prio;
      end else begin
        case (st)
          ST_HOLD: begin
            st  <= need_sys ? ST_SYS : ST_TAIL;
            cnt <= '0;
          end
          ST_SYS: if (sys_tick) begin
            if (cnt == CW'(SYS_LEN - 1)) begin
              st  <= ST_TAIL;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
          ST_TAIL: if (tail_tick) begin
            if (cnt == tail_len - 1'b1) st <= ST_RUN;
            else cnt <= cnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign core_rst = (st != ST_RUN);
endmodule

// File: rtl/rst_stretch_chk.sv
module rst_stretch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       por_req,
  input logic       pin_req,
  input logic       wdt_req,
  input logic       cfg_pin_keep,
  input logic       cfg_dbg_off,
  input logic       core_rst,
  input logic [1:0] cause,
  input logic       pin_ignored
);
  wire acc = por_req | wdt_req | (pin_req & cfg_pin_keep & cfg_dbg_off);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> core_rst);

  p_quiet_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_rst && $past(core_rst)) |-> !$past(acc));

  p_cause_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_rst && $past(!core_rst)) |-> $stable(cause));

  p_cause_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cause != 2'b00);

  p_ign_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pin_ignored |=> !pin_ignored);

  p_ign_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pin_ignored |-> ($past(pin_req) && !($past(cfg_pin_keep) && $past(cfg_dbg_off))));
endmodule

bind rst_stretch rst_stretch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .por_req(por_req), .pin_req(pin_req),
  .wdt_req(wdt_req), .cfg_pin_keep(cfg_pin_keep), .cfg_dbg_off(cfg_dbg_off),
  .core_rst(core_rst), .cause(cause), .pin_ignored(pin_ignored));

// File: tb/rst_stretch_tb_top.sv
module rst_stretch_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic por_req = 0, pin_req = 0, wdt_req = 0;
  logic cfg_xclk_off = 1, cfg_pin_keep = 1, cfg_dbg_off = 1;
  logic sys_tick = 0, rc_tick = 0, ext_tick = 0;
  logic core_rst, pin_ignored;
  logic [1:0] cause;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  rst_stretch dut_i (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] top_cause(logic p, logic n, logic w);
    return p ? 2'b01 : (w ? 2'b11 : 2'b10);
  endfunction

  function automatic void profile(logic [1:0] c, logic x, logic k, logic d,
                                  output int n1, output int n2, output int sel);
    n1 = 0; sel = x ? 0 : 1; n2 = 140;
    if (c == 2'b01) begin
      if (!x) n2 = 141;
      else if (k && d) n2 = 142;
      else n1 = 512;
    end else if (c == 2'b10) n2 = x ? 140 : 141;
    else n1 = 512;
  endfunction

  task automatic count_out(logic [1:0] ec, string tag);
    int n1, n2, sel, ph, k;
    profile(ec, cfg_xclk_off, cfg_pin_keep, cfg_dbg_off, n1, n2, sel);
    @(posedge clk); @(negedge clk);
    ph = (n1 > 0) ? 1 : 2; k = 0;
    forever begin
      logic ts, tr, te, hit, last;
      ts = 1'($urandom); tr = 1'($urandom); te = 1'($urandom);
      hit  = (ph == 1) ? ts : (sel ? te : tr);
      last = hit && ph == 2 && k == n2 - 1;
      if (last) chk({tag, " R7 still held before final tick"}, core_rst, 1);
      sys_tick = ts; rc_tick = tr; ext_tick = te;
      @(posedge clk); @(negedge clk);
      if (hit) begin
        if (ph == 1 && k == n1 - 1) begin ph = 2; k = 0; end
        else k++;
      end
      if (last) begin
        sys_tick = 0; rc_tick = 0; ext_tick = 0;
        chk({tag, " released on final tick"}, core_rst, 0);
        chk({tag, " R9 cause after release"}, cause, ec);
        break;
      end
    end
  endtask

  task automatic run_req(logic p, logic n, logic w, string tag);
    logic [1:0] ec;
    ec = top_cause(p, n, w);
    @(negedge clk); por_req = p; pin_req = n; wdt_req = w;
    repeat (3) @(negedge clk);
    chk({tag, " R1 held during request"}, core_rst, 1);
    chk({tag, " R9 cause priority"}, cause, ec);
    por_req = 0; pin_req = 0; wdt_req = 0;
    count_out(ec, tag);
  endtask

  task automatic set_cfg(logic x, logic k, logic d);
    @(negedge clk); cfg_xclk_off = x; cfg_pin_keep = k; cfg_dbg_off = d;
  endtask

  task automatic ignored_pin(string tag);
    logic [1:0] c0;
    c0 = cause;
    @(negedge clk); pin_req = 1;
    @(negedge clk);
    chk({tag, " R10 pulse"}, pin_ignored, 1);
    chk({tag, " R10 no reset"}, core_rst, 0);
    @(negedge clk);
    chk({tag, " R10 one cycle"}, pin_ignored, 0);
    chk({tag, " R10 cause kept"}, cause, c0);
    chk({tag, " R10 still running"}, core_rst, 0);
    pin_req = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R11 core_rst in reset", core_rst, 1);
    chk("R11 cause in reset", cause, 1);
    chk("R11 flag in reset", pin_ignored, 0);
    rst_n = 1;
    count_out(2'b01, "R11 R2 first power-on");

    for (int f = 0; f < 8; f++) begin
      set_cfg(f[2], f[1], f[0]);
      run_req(1, 0, 0, "R2 R3 R4 power-on");
    end
    set_cfg(1, 1, 1); run_req(0, 1, 0, "R5 pin rc");
    set_cfg(0, 1, 1); run_req(0, 1, 0, "R5 pin ext");
    set_cfg(1, 0, 1); run_req(0, 0, 1, "R6 wdt rc");
    set_cfg(0, 1, 0); run_req(0, 0, 1, "R6 wdt ext");
    set_cfg(1, 1, 1); run_req(1, 1, 1, "R9 all three");
    run_req(0, 1, 1, "R9 wdt over pin");

    set_cfg(1, 0, 1); ignored_pin("R5 pin disabled by keep");
    set_cfg(0, 1, 0); ignored_pin("R5 pin disabled by debug");

    set_cfg(1, 1, 1);
    @(negedge clk); wdt_req = 1;
    repeat (2) @(negedge clk); wdt_req = 0;
    @(negedge clk); sys_tick = 1;
    repeat (10) @(negedge clk);
    sys_tick = 0; pin_req = 1;
    @(negedge clk);
    chk("R8 reassert on new request", core_rst, 1);
    chk("R8 new cause latched", cause, 2);
    pin_req = 0;
    count_out(2'b10, "R8 restart");

    for (int i = 0; i < 20; i++) begin
      logic x, k, d, p, n, w;
      x = 1'($urandom); k = 1'($urandom); d = 1'($urandom);
      p = 1'($urandom); n = 1'($urandom); w = 1'($urandom);
      set_cfg(x, k, d);
      if (!(p | w | (n & k & d))) begin
        if (n) ignored_pin("R10 random ignored");
        w = 1;
      end
      run_req(p, n & k & d, w, "R1 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule